// File: doc/BRIEF.md
# Voice Channel Control Bank

This block is the register-side control plane of a 64-voice playback engine. A host reaches it through a simple synchronous port with word addresses. The five 32-bit parameter words of each voice are not mapped side by side. Instead, a voice-select register names one voice, and a window of five word addresses then reads and writes the parameters of that voice. The sample-fetch engine has its own read port. On that port it names any voice and receives that voice's parameter words, with the packed fields already split out.

The run state of each voice is controlled through write-one registers. The 6-bit voice index splits into a bank bit (bit 5) and a bit position (bits 4:0). Each bank holds 32 voices, and each bank has its own start, stop, interrupt-enable and interrupt-status word. The engine reports address events as per-voice pulses, and these are latched into the status banks. A cause register gives a summary of the enabled address interrupts, kept separate from a record-path pending flag. A single interrupt line is the OR of the two causes.

Top module: `voice_ctl_bank`

## Requirements
- R1: After a synchronous active-low reset, `voice_run` is all zero and `irq` is low, and the voice-select (word 5), run (word 6), status and cause words read zero.
- R2: Word 5 is the voice-select register. Its bits 5:0 pick the voice that word addresses 0 to 4 access, and all 32 bits read back exactly as written.
- R3: Voice v maps to bank A (words 6, 8, 10, 12), bit v, when v < 32. It maps to bank B (words 7, 9, 11, 13), bit v-32, otherwise. `voice_run[v]` is the run state of voice v.
- R4: Writing a 1 to a bit of the start words (6 for bank A, 7 for bank B) sets that voice's run bit on the next clock. Zero bits leave the state unchanged. Reading a start word returns the run bits of that bank.
- R5: Writing a 1 to a bit of the stop words (8 for bank A, 9 for bank B) clears that voice's run bit. Zero bits have no effect. Stop words read zero.
- R6: Parameter word 1 keeps only bits 29:0, so bits 31:30 always read zero. The engine sees bits 29:0 as `eng_base`.
- R7: Parameter word 4 is decoded for the engine as follows: bit 31 is `eng_gsel`, bits 30:24 are `eng_pan`, bits 23:16 are `eng_vol`, bits 15:12 are `eng_fmt` and bits 11:0 are `eng_env`.
- R8: Interrupt-enable words 10 (bank A) and 11 (bank B) are plain read/write registers with one bit per voice.
- R9: A pulse on `addr_evt[v]` sets voice v's status bit, which is read in word 12 (bank A) or word 13 (bank B). Writing a 1 to a status bit clears it, and zero bits have no effect. An event in the same cycle as its clear leaves the bit set.
- R10: Cause word 14 works as follows. Bit 0 is the OR over all voices of status AND enable. Bit 1 is a record flag that `rec_evt` sets and that writing a 1 to bit 1 clears. `irq` is bit 0 OR bit 1.
- R11: `eng_voice` selects the voice shown on the engine outputs, independent of the host voice-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 4 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data (combinational from address) |
| addr_evt | input | 64 | Per-voice address-event pulses from the engine |
| rec_evt | input | 1 | Record-path interrupt event |
| eng_voice | input | 6 | Voice selected on the engine read port |
| eng_word0 | output | 32 | Parameter word 0 of the engine voice |
| eng_base | output | 30 | Base address from word 1 |
| eng_word2 | output | 32 | Parameter word 2 of the engine voice |
| eng_word3 | output | 32 | Parameter word 3 of the engine voice |
| eng_gsel | output | 1 | Selector bit from word 4 |
| eng_pan | output | 7 | Pan from word 4 |
| eng_vol | output | 8 | Volume from word 4 |
| eng_fmt | output | 4 | Control/format from word 4 |
| eng_env | output | 12 | Envelope field from word 4 |
| voice_run | output | 64 | Run state per voice |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions check several properties on every clock:
- A start write raises every run bit it names.
- A stop write clears every run bit it names.
- The run vector holds still when neither kind of write occurs.
- An enabled address event raises `irq` on the next cycle.
- Word 1 never reads back its reserved top bits.

Other behaviours can only be shown by the bench's scenarios, because they depend on stored history:
- The voice-select window routing, with one voice's parameters kept apart from another's.
- The field split of word 4.
- Priority of an event over a same-cycle clear.
- The record flag and its clear-by-bit rule.
- Recovery from a mid-run reset.

// File: rtl/vcb_pkg.sv
// Shared constants for the voice channel control bank: sizes, the word
// address map and the per-word write masks for parameter storage.
package vcb_pkg;
    localparam int NUM_VOICES  = 64;
    localparam int WORD_W      = 32;
    localparam int PARAM_WORDS = 5;
    localparam int BANK_W      = 32;
    localparam int NUM_BANKS   = NUM_VOICES / BANK_W;
    localparam int VIDX_W      = $clog2(NUM_VOICES);
    localparam int ADDR_W      = 4;
    localparam int BASE_W      = 30;

    // Word address map (host side)
    localparam int RA_CHSEL      = 5;
    localparam int RA_START_BASE = 6;
    localparam int RA_STOP_BASE  = 8;
    localparam int RA_IEN_BASE   = 10;
    localparam int RA_STAT_BASE  = 12;
    localparam int RA_CAUSE      = 14;

    // Cause register bit positions
    localparam int CAUSE_ADDR_BIT = 0;
    localparam int CAUSE_REC_BIT  = 1;

    // Write mask per parameter word: word 1 holds only a 30-bit base address
    function automatic logic [WORD_W-1:0] word_mask(input int idx);
        logic [WORD_W-1:0] m;
        m = '1;
        if (idx == 1) m = {{(WORD_W-BASE_W){1'b0}}, {BASE_W{1'b1}}};
        return m;
    endfunction
endpackage

// File: rtl/vcb_param_store.sv
// Parameter storage: VOICES x WORDS words, one host write/read port and one
// engine read port returning all words of a voice. Assumes the caller only
// asserts we for word indices below WORDS.
module vcb_param_store #(
    parameter int VOICES = vcb_pkg::NUM_VOICES,
    parameter int WORDS  = vcb_pkg::PARAM_WORDS,
    parameter int W      = vcb_pkg::WORD_W,
    localparam int VI_W  = $clog2(VOICES),
    localparam int WI_W  = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [VI_W-1:0]      host_voice,
    input  logic [WI_W-1:0]      host_word,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         host_rdata,
    input  logic [VI_W-1:0]      eng_voice,
    output logic [WORDS*W-1:0]   eng_words
);
    logic [W-1:0] store [VOICES][WORDS];

    // Reset all words; masked host write into the selected voice/word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < VOICES; v++)
                for (int w = 0; w < WORDS; w++)
                    store[v][w] <= '0;
        end else if (we) begin
            for (int w = 0; w < WORDS; w++)
                if (host_word == WI_W'(w))
                    store[host_voice][w] <= wdata & W'(vcb_pkg::word_mask(w));
        end
    end

    // Host read of the selected voice/word
    always_comb begin
        host_rdata = '0;
        for (int w = 0; w < WORDS; w++)
            if (host_word == WI_W'(w)) host_rdata = store[host_voice][w];
    end

    // Engine port: all words of the engine-selected voice
    for (genvar g = 0; g < WORDS; g++) begin : g_eng
        assign eng_words[g*W +: W] = store[eng_voice][g];
    end
endmodule

// File: rtl/vcb_voice_bank.sv
// One bank of per-voice control: run state with write-one start/stop (stop
// wins on a shared bit), a plain enable register, and a status register
// set by events and cleared by write-one (an event wins over its clear).
module vcb_voice_bank #(
    parameter int BW = vcb_pkg::BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_we,
    input  logic          stop_we,
    input  logic          ien_we,
    input  logic          stat_we,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] evt,
    output logic [BW-1:0] run,
    output logic [BW-1:0] ien,
    output logic [BW-1:0] stat
);
    logic [BW-1:0] set_bits, clr_bits, ack_bits;

    // Decode write-one masks from the current write
    always_comb begin
        set_bits = start_we ? wdata : '0;
        clr_bits = stop_we  ? wdata : '0;
        ack_bits = stat_we  ? wdata : '0;
    end

    // Run state: set by start bits, then cleared by stop bits
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else        run <= (run | set_bits) & ~clr_bits;
    end

    // Interrupt enable: plain register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (ien_we) ien <= wdata;
    end

    // Status: write-one clear, event set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~ack_bits) | evt;
    end
endmodule

// File: rtl/vcb_irq_sum.sv
// Interrupt summary: reduces enabled status over all voices, holds the
// record-path pending flag, and forms the single interrupt line.
module vcb_irq_sum #(
    parameter int VOICES = vcb_pkg::NUM_VOICES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VOICES-1:0] stat,
    input  logic [VOICES-1:0] ien,
    input  logic              rec_evt,
    input  logic              rec_clr,
    output logic              addr_sum,
    output logic              rec_pend,
    output logic              irq
);
    // Record flag: event sets, write-one clears, event wins
    always_ff @(posedge clk) begin
        if (!rst_n) rec_pend <= 1'b0;
        else        rec_pend <= (rec_pend & ~rec_clr) | rec_evt;
    end

    // Enabled address-interrupt summary and output line
    always_comb begin
        addr_sum = |(stat & ien);
        irq      = addr_sum | rec_pend;
    end
endmodule

// File: rtl/voice_ctl_bank.sv
// Top of the voice channel control bank. Decodes the host word address into
// the parameter window, the voice-select register and the per-bank control
// words, and splits the engine voice's packed parameter fields. Reads are
// combinational from the address; writes take effect at the clock edge.
module voice_ctl_bank #(
    parameter int VOICES = vcb_pkg::NUM_VOICES,
    parameter int BANK_W = vcb_pkg::BANK_W,
    parameter int W      = vcb_pkg::WORD_W,
    parameter int PWORDS = vcb_pkg::PARAM_WORDS,
    parameter int ADDR_W = vcb_pkg::ADDR_W,
    localparam int NBANK = VOICES / BANK_W,
    localparam int VI_W  = $clog2(VOICES),
    localparam int WI_W  = $clog2(PWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [VOICES-1:0] addr_evt,
    input  logic              rec_evt,
    input  logic [VI_W-1:0]   eng_voice,
    output logic [W-1:0]      eng_word0,
    output logic [29:0]       eng_base,
    output logic [W-1:0]      eng_word2,
    output logic [W-1:0]      eng_word3,
    output logic              eng_gsel,
    output logic [6:0]        eng_pan,
    output logic [7:0]        eng_vol,
    output logic [3:0]        eng_fmt,
    output logic [11:0]       eng_env,
    output logic [VOICES-1:0] voice_run,
    output logic              irq
);
    import vcb_pkg::*;

    logic [W-1:0]        chsel;
    logic                win_we;
    logic [W-1:0]        win_rdata;
    logic [PWORDS*W-1:0] eng_words;
    logic [BANK_W-1:0]   run_bk  [NBANK];
    logic [BANK_W-1:0]   ien_bk  [NBANK];
    logic [BANK_W-1:0]   stat_bk [NBANK];
    logic [VOICES-1:0]   ien_all, stat_all;
    logic                addr_sum, rec_pend, rec_clr;

    // Voice-select register: all bits stored, low bits pick the voice
    always_ff @(posedge clk) begin
        if (!rst_n)                                      chsel <= '0;
        else if (bus_we && bus_addr == ADDR_W'(RA_CHSEL)) chsel <= bus_wdata;
    end

    // Window write strobe for the parameter words
    assign win_we = bus_we && (bus_addr < ADDR_W'(PWORDS));

    vcb_param_store #(.VOICES(VOICES), .WORDS(PWORDS), .W(W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (win_we),
        .host_voice (chsel[VI_W-1:0]),
        .host_word  (bus_addr[WI_W-1:0]),
        .wdata      (bus_wdata),
        .host_rdata (win_rdata),
        .eng_voice  (eng_voice),
        .eng_words  (eng_words)
    );

    // One control bank per group of BANK_W voices
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        vcb_voice_bank #(.BW(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_we (bus_we && bus_addr == ADDR_W'(RA_START_BASE + b)),
            .stop_we  (bus_we && bus_addr == ADDR_W'(RA_STOP_BASE + b)),
            .ien_we   (bus_we && bus_addr == ADDR_W'(RA_IEN_BASE + b)),
            .stat_we  (bus_we && bus_addr == ADDR_W'(RA_STAT_BASE + b)),
            .wdata    (bus_wdata[BANK_W-1:0]),
            .evt      (addr_evt[b*BANK_W +: BANK_W]),
            .run      (run_bk[b]),
            .ien      (ien_bk[b]),
            .stat     (stat_bk[b])
        );
        assign voice_run[b*BANK_W +: BANK_W] = run_bk[b];
        assign ien_all[b*BANK_W +: BANK_W]   = ien_bk[b];
        assign stat_all[b*BANK_W +: BANK_W]  = stat_bk[b];
    end

    // Write-one clear of the record flag through the cause word
    assign rec_clr = bus_we && bus_addr == ADDR_W'(RA_CAUSE) && bus_wdata[CAUSE_REC_BIT];

    vcb_irq_sum #(.VOICES(VOICES)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (stat_all),
        .ien      (ien_all),
        .rec_evt  (rec_evt),
        .rec_clr  (rec_clr),
        .addr_sum (addr_sum),
        .rec_pend (rec_pend),
        .irq      (irq)
    );

    // Host read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(PWORDS)) bus_rdata = win_rdata;
        if (bus_addr == ADDR_W'(RA_CHSEL)) bus_rdata = chsel;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == ADDR_W'(RA_START_BASE + b)) bus_rdata = W'(run_bk[b]);
            if (bus_addr == ADDR_W'(RA_IEN_BASE + b))   bus_rdata = W'(ien_bk[b]);
            if (bus_addr == ADDR_W'(RA_STAT_BASE + b))  bus_rdata = W'(stat_bk[b]);
        end
        if (bus_addr == ADDR_W'(RA_CAUSE)) begin
            bus_rdata[CAUSE_ADDR_BIT] = addr_sum;
            bus_rdata[CAUSE_REC_BIT]  = rec_pend;
        end
    end

    // Engine-side field split of the selected voice's words
    always_comb begin
        eng_word0 = eng_words[0*W +: W];
        eng_base  = eng_words[1*W +: 30];
        eng_word2 = eng_words[2*W +: W];
        eng_word3 = eng_words[3*W +: W];
        eng_gsel  = eng_words[4*W + 31];
        eng_pan   = eng_words[4*W + 24 +: 7];
        eng_vol   = eng_words[4*W + 16 +: 8];
        eng_fmt   = eng_words[4*W + 12 +: 4];
        eng_env   = eng_words[4*W +: 12];
    end
endmodule

// File: rtl/vcb_checker.sv
// Cycle checks for the voice channel control bank, bound to the top.
// Assumes the default word map (start 6, stop 8, window word 1).
module vcb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [63:0] addr_evt,
    input logic [63:0] ien_all,
    input logic [63:0] voice_run,
    input logic        irq
);
    // R4: start bits named in a bank-A start write are running next cycle
    assert_start_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'd6) |=>
        ((voice_run[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R5: stop bits named in a bank-A stop write are idle next cycle
    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'd8) |=> ((voice_run[31:0] & $past(bus_wdata)) == 32'd0));

    // R4/R5: run state only moves on start/stop writes
    assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr >= 4'd6 && bus_addr <= 4'd9) |=> $stable(voice_run));

    // R10: an enabled address event raises the interrupt next cycle
    assert_evt_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(addr_evt & ien_all)) |=> irq);

    // R6: reserved top bits of word 1 never read back
    assert_base_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd1) |-> (bus_rdata[31:30] == 2'b00));
endmodule

bind voice_ctl_bank vcb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .addr_evt  (addr_evt),
    .ien_all   (ien_all),
    .voice_run (voice_run),
    .irq       (irq)
);

// File: tb/voice_ctl_bank_test.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module voice_ctl_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] addr_evt = '0;
    logic        rec_evt = 1'b0;
    logic [5:0]  eng_voice = '0;
    logic [31:0] eng_word0, eng_word2, eng_word3;
    logic [29:0] eng_base;
    logic        eng_gsel;
    logic [6:0]  eng_pan;
    logic [7:0]  eng_vol;
    logic [3:0]  eng_fmt;
    logic [11:0] eng_env;
    logic [63:0] voice_run;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    voice_ctl_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_evt(addr_evt),
        .rec_evt(rec_evt), .eng_voice(eng_voice), .eng_word0(eng_word0),
        .eng_base(eng_base), .eng_word2(eng_word2), .eng_word3(eng_word3),
        .eng_gsel(eng_gsel), .eng_pan(eng_pan), .eng_vol(eng_vol),
        .eng_fmt(eng_fmt), .eng_env(eng_env), .voice_run(voice_run), .irq(irq)
    );

    // {write, addr, data/expected, requirement number}
    localparam int NV = 24;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 4'd5,  32'hABCD0005, 4'd2},   // R2 select voice 5, upper bits kept
        {1'b0, 4'd5,  32'hABCD0005, 4'd2},
        {1'b1, 4'd0,  32'h11111111, 4'd2},
        {1'b1, 4'd1,  32'hFFFFFFFF, 4'd6},
        {1'b0, 4'd1,  32'h3FFFFFFF, 4'd6},   // R6 masked base
        {1'b1, 4'd5,  32'h00000025, 4'd2},   // voice 37
        {1'b1, 4'd0,  32'h22222222, 4'd2},
        {1'b0, 4'd0,  32'h22222222, 4'd2},
        {1'b0, 4'd1,  32'h00000000, 4'd2},
        {1'b1, 4'd5,  32'hABCD0005, 4'd2},
        {1'b0, 4'd0,  32'h11111111, 4'd2},
        {1'b1, 4'd6,  32'h00000021, 4'd4},   // R4 start
        {1'b0, 4'd6,  32'h00000021, 4'd4},
        {1'b1, 4'd6,  32'h00000004, 4'd4},
        {1'b0, 4'd6,  32'h00000025, 4'd4},   // zero bits keep
        {1'b1, 4'd7,  32'h80000000, 4'd3},   // R3 voice 63
        {1'b0, 4'd7,  32'h80000000, 4'd3},
        {1'b1, 4'd8,  32'h00000001, 4'd5},   // R5 stop voice 0
        {1'b0, 4'd6,  32'h00000024, 4'd5},
        {1'b0, 4'd8,  32'h00000000, 4'd5},
        {1'b0, 4'd7,  32'h80000000, 4'd5},
        {1'b1, 4'd10, 32'h0000F00F, 4'd8},   // R8 enable
        {1'b0, 4'd10, 32'h0000F00F, 4'd8},
        {1'b0, 4'd14, 32'h00000000, 4'd10}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d,
                      input logic [63:0] ev = '0, input logic rv = 1'b0);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; addr_evt = ev; rec_evt = rv;
        @(negedge clk);
        bus_we = 1'b0; addr_evt = '0; rec_evt = 1'b0;
    endtask

    task automatic pulse(input logic [63:0] ev, input logic rv);
        @(negedge clk);
        addr_evt = ev; rec_evt = rv;
        @(negedge clk);
        addr_evt = '0; rec_evt = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd5, d);  check("R1 chsel", 64'(d), 64'h0);
        rd(4'd6, d);  check("R1 run", 64'(d), 64'h0);
        rd(4'd14, d); check("R1 cause", 64'(d), 64'h0);
        check("R1 voice_run", voice_run, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) wr(VEC[i][39:36], VEC[i][35:4]);
            else begin
                rd(VEC[i][39:36], d);
                check($sformatf("R%0d table[%0d]", VEC[i][3:0], i), 64'(d), 64'(VEC[i][35:4]));
            end
        end

        // R3 port mapping of run bits: voices 2, 5, 63
        check("R3 voice_run", voice_run, 64'h8000000000000024);

        // R7 and R11 engine field split
        wr(4'd4, 32'hD5A79123);
        @(negedge clk); eng_voice = 6'd5; #1;
        check("R7 gsel", 64'(eng_gsel), 64'h1);
        check("R7 pan", 64'(eng_pan), 64'h55);
        check("R7 vol", 64'(eng_vol), 64'hA7);
        check("R7 fmt", 64'(eng_fmt), 64'h9);
        check("R7 env", 64'(eng_env), 64'h123);
        check("R6 eng_base", 64'(eng_base), 64'h3FFFFFFF);
        check("R11 word0 v5", 64'(eng_word0), 64'h11111111);
        @(negedge clk); eng_voice = 6'd37; #1;
        check("R11 word0 v37", 64'(eng_word0), 64'h22222222);

        // R9/R10 address events
        pulse(64'h8, 1'b0);
        rd(4'd12, d); check("R9 stat A", 64'(d), 64'h8);
        check("R10 irq on", 64'(irq), 64'h1);
        rd(4'd14, d); check("R10 cause addr", 64'(d), 64'h1);
        pulse(64'h1 << 40, 1'b0);
        rd(4'd13, d); check("R9 stat B", 64'(d), 64'h100);
        wr(4'd12, 32'h8);
        rd(4'd12, d); check("R9 clear A", 64'(d), 64'h0);
        check("R10 irq off", 64'(irq), 64'h0);
        wr(4'd13, 32'h0);
        rd(4'd13, d); check("R9 zero no effect", 64'(d), 64'h100);
        wr(4'd13, 32'h100, 64'h1 << 40);
        rd(4'd13, d); check("R9 event wins", 64'(d), 64'h100);
        wr(4'd13, 32'h100);
        rd(4'd13, d); check("R9 clear B", 64'(d), 64'h0);

        // R8 bank B enable feeds the summary
        wr(4'd11, 32'h100);
        rd(4'd11, d); check("R8 ien B", 64'(d), 64'h100);
        pulse(64'h1 << 40, 1'b0);
        rd(4'd14, d); check("R10 cause B", 64'(d), 64'h1);
        wr(4'd13, 32'h100);

        // R10 record flag
        pulse(64'h0, 1'b1);
        rd(4'd14, d); check("R10 rec set", 64'(d), 64'h2);
        check("R10 rec irq", 64'(irq), 64'h1);
        wr(4'd14, 32'h1);
        rd(4'd14, d); check("R10 rec kept", 64'(d), 64'h2);
        wr(4'd14, 32'h2);
        rd(4'd14, d); check("R10 rec clear", 64'(d), 64'h0);
        check("R10 irq idle", 64'(irq), 64'h0);

        // R1 reset mid-run
        pulse(64'h8, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 run after reset", voice_run, 64'h0);
        check("R1 irq after reset", 64'(irq), 64'h0);
        rd(4'd5, d);  check("R1 chsel after reset", 64'(d), 64'h0);
        rd(4'd12, d); check("R1 stat after reset", 64'(d), 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule